// File: doc/BRIEF.md
# Two-Requester Shared-Memory Arbiter

This block decides which of two processors may use one shared memory. Each processor raises its own request line and watches its own grant line. The arbiter is a Moore machine with two state flip-flops, and those flip-flops drive the grant outputs directly. The grants therefore change only on a clock edge and never glitch.

Arbitration does not preempt. Processor A is preferred only when both processors ask in the same cycle while the memory is free. Once a processor holds the grant, it keeps it for as long as it keeps requesting, whatever the other side does.

When the owner lowers its request, its grant falls at the next edge. A processor that was waiting receives the grant one edge after that. The idle cycle between owners comes from the next-state equations, which look at the current grants. A synchronous, active-high reset returns the arbiter to the idle state, with neither grant set.

Top module: `arb2_mem_arbiter`

## Requirements
- R1: While `rst` is high at a rising clock edge, both grants are 0 after that edge, whatever the request inputs are.
- R2: `gnt_a` and `gnt_b` are never 1 in the same cycle.
- R3: From idle (both grants 0), if only `req_a` is 1 at an edge, then `gnt_a` becomes 1 after that edge.
- R4: From idle, if only `req_b` is 1 at an edge, then `gnt_b` becomes 1 after that edge.
- R5: From idle, if `req_a` and `req_b` are both 1 at the same edge, then `gnt_a` becomes 1 and `gnt_b` stays 0.
- R6: While `gnt_a` is 1 and `req_a` is 1 at an edge, `gnt_a` stays 1 and `gnt_b` stays 0, whatever `req_b` is.
- R7: While `gnt_b` is 1 and `req_b` is 1 at an edge, `gnt_b` stays 1 and `gnt_a` stays 0, whatever `req_a` is.
- R8: When the grant owner's request is 0 at an edge, both grants are 0 after that edge, even if the other side is requesting. The waiting side is granted at the edge after that.
- R9: From idle, with no request at an edge, both grants stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to idle |
| req_a | input | 1 | Request from processor A (preferred on ties) |
| req_b | input | 1 | Request from processor B |
| gnt_a | output | 1 | Grant to processor A, driven straight from a state flip-flop |
| gnt_b | output | 1 | Grant to processor B, driven straight from a state flip-flop |

## Verification
The bound checker watches four things on every cycle:
- the two grants are never set together;
- a grant is held while its owner keeps requesting;
- a grant is released after its owner stops requesting;
- idle resolves correctly, including a tie, which goes to A.

The bench has to show the rest through scenarios:
- reset taking effect while a grant is held;
- the one-cycle gap before a waiting requester takes over;
- every request combination applied from each reachable state.

A long pseudo-random request stream is compared cycle by cycle with a model that the bench works out from the requirements.

// File: rtl/arb2_pkg.sv
package arb2_pkg;

    // One bit per requester: requests and grants share this layout.
    typedef struct packed {
        logic b;
        logic a;
    } pair_t;

    localparam pair_t IDLE = '{b: 1'b0, a: 1'b0};

    // A may take the memory unless B currently owns it.
    function automatic logic want_a(input pair_t req, input pair_t cur);
        return req.a & ~cur.b;
    endfunction

    // B keeps its grant while requesting, or takes a free memory that A does not ask for.
    function automatic logic want_b(input pair_t req, input pair_t cur);
        return req.b & (cur.b | (~req.a & ~cur.a));
    endfunction

    function automatic pair_t step(input pair_t req, input pair_t cur);
        pair_t n;
        n.a = want_a(req, cur);
        n.b = want_b(req, cur);
        return n;
    endfunction

endpackage

// File: rtl/arb2_next_state.sv
module arb2_next_state
    import arb2_pkg::*;
(
    input  pair_t req,
    input  pair_t cur,
    output pair_t nxt
);
    always_comb begin
        nxt = step(req, cur);
    end
endmodule

// File: rtl/arb2_state_reg.sv
module arb2_state_reg
    import arb2_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pair_t d,
    output pair_t q
);
    always_ff @(posedge clk) begin
        if (rst) q <= IDLE;
        else     q <= d;
    end
endmodule

// File: rtl/arb2_mem_arbiter.sv
module arb2_mem_arbiter
    import arb2_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_a,
    input  logic req_b,
    output logic gnt_a,
    output logic gnt_b
);
    pair_t req_w;
    pair_t cur_w;
    pair_t nxt_w;

    assign req_w = '{b: req_b, a: req_a};

    arb2_next_state u_next (
        .req (req_w),
        .cur (cur_w),
        .nxt (nxt_w)
    );

    arb2_state_reg u_state (
        .clk (clk),
        .rst (rst),
        .d   (nxt_w),
        .q   (cur_w)
    );

    // Moore outputs: the grants are the state bits themselves.
    assign gnt_a = cur_w.a;
    assign gnt_b = cur_w.b;
endmodule

// File: rtl/arb2_checker.sv
module arb2_checker (
    input logic clk,
    input logic rst,
    input logic req_a,
    input logic req_b,
    input logic gnt_a,
    input logic gnt_b
);
    a_r2_mutex: assert property (@(posedge clk) disable iff (rst)
        !(gnt_a && gnt_b));

    a_r6_hold_a: assert property (@(posedge clk) disable iff (rst)
        (gnt_a && req_a) |=> (gnt_a && !gnt_b));

    a_r7_hold_b: assert property (@(posedge clk) disable iff (rst)
        (gnt_b && req_b) |=> (gnt_b && !gnt_a));

    a_r8_release_a: assert property (@(posedge clk) disable iff (rst)
        (gnt_a && !req_a) |=> (!gnt_a && !gnt_b));

    a_r8_release_b: assert property (@(posedge clk) disable iff (rst)
        (gnt_b && !req_b) |=> (!gnt_a && !gnt_b));

    a_r5_tie: assert property (@(posedge clk) disable iff (rst)
        (!gnt_a && !gnt_b && req_a && req_b) |=> (gnt_a && !gnt_b));

    a_r4_only_b: assert property (@(posedge clk) disable iff (rst)
        (!gnt_a && !gnt_b && !req_a && req_b) |=> gnt_b);

    a_r9_idle: assert property (@(posedge clk) disable iff (rst)
        (!gnt_a && !gnt_b && !req_a && !req_b) |=> (!gnt_a && !gnt_b));
endmodule

bind arb2_mem_arbiter arb2_checker u_arb2_checker (
    .clk   (clk),
    .rst   (rst),
    .req_a (req_a),
    .req_b (req_b),
    .gnt_a (gnt_a),
    .gnt_b (gnt_b)
);

// File: tb/test_arb2_mem_arbiter.sv
module test_arb2_mem_arbiter;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_a = 1'b0;
    logic req_b = 1'b0;
    logic gnt_a;
    logic gnt_b;

    int total = 0;
    int bad = 0;
    logic ea = 1'b0;
    logic eb = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    arb2_mem_arbiter i_arb2_mem_arbiter (
        .clk   (clk),
        .rst   (rst),
        .req_a (req_a),
        .req_b (req_b),
        .gnt_a (gnt_a),
        .gnt_b (gnt_b)
    );

    task automatic chk(input string tag, input logic [1:0] got, input logic [1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got {b,a}=%b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic string tag_of(input logic pa, input logic pb, input logic ra, input logic rb);
        if (pa) return ra ? "R6" : "R8";
        if (pb) return rb ? "R7" : "R8";
        if (ra && rb) return "R5";
        if (ra) return "R3";
        if (rb) return "R4";
        return "R9";
    endfunction

    // Apply requests, clock once, compare with the expected grants.
    task automatic drive(input logic ra, input logic rb);
        logic na, nb;
        string t;
        req_a = ra;
        req_b = rb;
        t = tag_of(ea, eb, ra, rb);
        na = ra && !eb;
        nb = rb && (eb || (!ra && !ea));
        @(posedge clk);
        @(negedge clk);
        ea = na;
        eb = nb;
        chk(t, {gnt_b, gnt_a}, {eb, ea});
        total++;
        if (gnt_a && gnt_b) begin
            bad++;
            $display("FAIL R2: got {b,a}=%b expected not 11", {gnt_b, gnt_a});
        end
    endtask

    task automatic do_reset(input logic ra, input logic rb);
        rst = 1'b1;
        req_a = ra;
        req_b = rb;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        ea = 1'b0;
        eb = 1'b0;
        chk("R1", {gnt_b, gnt_a}, 2'b00);
    endtask

    initial begin
        @(negedge clk);
        do_reset(1'b1, 1'b1);

        // R1: reset while A holds the grant and both sides keep requesting.
        drive(1'b1, 1'b0);
        do_reset(1'b1, 1'b1);

        // R8: handover from A to B takes one idle cycle.
        drive(1'b1, 1'b1);
        drive(1'b1, 1'b1);
        drive(1'b0, 1'b1);
        chk("R8", {gnt_b, gnt_a}, 2'b00);
        drive(1'b0, 1'b1);
        chk("R8", {gnt_b, gnt_a}, 2'b10);
        drive(1'b1, 1'b1);
        chk("R7", {gnt_b, gnt_a}, 2'b10);

        // Sweep: every reachable start state against every request pair.
        for (int s = 0; s < 3; s++) begin
            for (int c = 0; c < 4; c++) begin
                do_reset(1'b0, 1'b0);
                if (s == 1) drive(1'b1, 1'b0);
                if (s == 2) drive(1'b0, 1'b1);
                drive(c[0], c[1]);
            end
        end

        // Pseudo-random request stream.
        do_reset(1'b0, 1'b0);
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            drive(lfsr[0], lfsr[3]);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule